// File: doc/BRIEF.md
# Structural-Stream Prefetch Address Generator

This block turns one demand access into a short burst of prefetch addresses. The access's cache block address is first translated through a physical-to-structural map into a structural address. A structural-to-physical map is then read at the structural positions that follow it. Each populated position yields the physical block to prefetch. Blocks that are far apart in physical memory but were touched one after another end up with adjacent structural addresses, so the burst follows the learned access order rather than the next physical lines.

Both maps sit outside the block. Each map line holds `SLOTS` (16) slots and has a combinational read port: the block drives a line tag, a slot index and a secure bit, and gets back a hit flag plus that slot's counter and stored address in the same cycle. The block handles one trigger at a time. It emits at most one prefetch per cycle through a valid/ready output and takes no new trigger until the burst has fully drained. Training of the maps and the prefetch queue are outside this block.

Top module: `sgen_prefetch_gen`

## Requirements
- R1: After reset, `trig_ready` is 1, `pf_valid` is 0 and `pf_err` is 0.
- R2: The trigger block address B is looked up in the physical-to-structural map at line tag B>>4 and slot B[3:0], with the trigger's secure bit. If that line misses for this tag and secure value, or the slot counter is 0, the trigger produces no prefetch and no error.
- R3: For a valid structural address S, the structural-to-physical line with tag S>>4 is read. If that line misses, `pf_err` pulses high for exactly one cycle and the trigger produces no prefetch.
- R4: Slots S[3:0]+1, S[3:0]+2 and so on are visited in ascending order, `DEGREE` (4) of them at most. Prefetches leave in visit order.
- R5: The walk never reaches past slot 15 of the line and never moves into the next line. When S[3:0] is 15, nothing is emitted and no error is raised.
- R6: A visited slot whose counter is 0 produces no prefetch. Every visited slot with a nonzero counter produces exactly one.
- R7: A prefetch address is the slot's stored block address shifted left by `OFF_W` (6), so it is a byte address. `pf_secure` equals the trigger's secure bit and `pf_prio` is 0.
- R8: While `pf_valid` is 1 and `pf_ready` is 0, `pf_valid` stays 1 and `pf_addr` stays unchanged.
- R9: `trig_ready` is 0 from the cycle after a trigger is accepted until the walk is done and the last prefetch has been taken. `pf_valid` is never 1 while `trig_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| trig_valid | input | 1 | Trigger access present |
| trig_ready | output | 1 | Block idle; trigger accepted |
| trig_blk | input | BLK_W | Trigger cache block address |
| trig_secure | input | 1 | Trigger secure-space bit |
| ps_rd_en | output | 1 | Physical-to-structural read active |
| ps_rd_tag | output | BLK_W-4 | Physical-to-structural line tag |
| ps_rd_slot | output | 4 | Physical-to-structural slot index |
| ps_rd_secure | output | 1 | Secure bit for the physical-to-structural read |
| ps_rd_hit | input | 1 | Physical-to-structural line present |
| ps_rd_cnt | input | CNT_W | Confidence counter of the read slot |
| ps_rd_saddr | input | STRUCT_W | Structural address of the read slot |
| sp_rd_en | output | 1 | Structural-to-physical read active |
| sp_rd_tag | output | STRUCT_W-4 | Structural-to-physical line tag |
| sp_rd_slot | output | 4 | Structural-to-physical slot index |
| sp_rd_secure | output | 1 | Secure bit for the structural-to-physical read |
| sp_rd_hit | input | 1 | Structural-to-physical line present |
| sp_rd_cnt | input | CNT_W | Confidence counter of the read slot |
| sp_rd_blk | input | BLK_W | Physical block address of the read slot |
| pf_valid | output | 1 | Prefetch address valid |
| pf_ready | input | 1 | Consumer takes the prefetch |
| pf_addr | output | BLK_W+OFF_W | Prefetch byte address |
| pf_secure | output | 1 | Secure bit of the prefetch |
| pf_prio | output | PRIO_W | Prefetch priority (always 0) |
| pf_err | output | 1 | One-cycle pulse: structural-to-physical line missing |

## Verification
Directed triggers cover each way a burst can end or fail to start. One trigger misses the first map outright and another hits it only with the other secure bit. A hit slot with a zero counter tells a line miss apart from an unconfident slot. A missing second-map line separates the error path from a quiet miss. Starting slots 0, 14 and 15 distinguish the degree limit from the line-end stop, and a line with zero-counter holes checks that the walk skips empty slots without stopping. Randomised maps and triggers then mix all of these cases, while a randomly throttled `pf_ready` tests ordering and the hold rule under backpressure.

// File: rtl/sgen_pkg.sv
package sgen_pkg;
    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_PSLK  = 3'd1,
        ST_SPCHK = 3'd2,
        ST_WALK  = 3'd3,
        ST_DRAIN = 3'd4
    } sgen_state_e;
endpackage

// File: rtl/sgen_slot_walker.sv
// Works out the slot visited at a given step and whether this is the last step.
module sgen_slot_walker #(
    parameter int SLOTS  = 16,
    parameter int DEGREE = 4
) (
    input  logic [$clog2(SLOTS)-1:0]    base_slot,
    input  logic [$clog2(DEGREE+1)-1:0] step,
    output logic [$clog2(SLOTS)-1:0]    slot,
    output logic                        last
);
    localparam int SLOT_W = $clog2(SLOTS);
    localparam int STEP_W = $clog2(DEGREE+1);
    localparam int SUM_W  = ((SLOT_W > STEP_W) ? SLOT_W : STEP_W) + 1;

    logic [SUM_W-1:0] sum;

    always_comb begin
        sum  = SUM_W'(base_slot) + SUM_W'(step);
        slot = sum[SLOT_W-1:0];
        last = (step == STEP_W'(DEGREE)) || (sum == SUM_W'(SLOTS-1));
    end
endmodule

// File: rtl/sgen_pf_out.sv
// One-entry output register with valid/ready hold.
module sgen_pf_out #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic         load_valid,
    input  logic [W-1:0] load_data,
    input  logic         pop,
    output logic         valid,
    output logic [W-1:0] data
);
    typedef struct packed {
        logic         vld;
        logic [W-1:0] dat;
    } out_t;

    out_t o_d, o_q;

    always_comb begin
        o_d = o_q;
        if (load) begin
            o_d.vld = load_valid;
            if (load_valid) o_d.dat = load_data;
        end else if (o_q.vld && pop) begin
            o_d.vld = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) o_q <= '0;
        else        o_q <= o_d;
    end

    assign valid = o_q.vld;
    assign data  = o_q.dat;
endmodule

// File: rtl/sgen_prefetch_gen.sv
module sgen_prefetch_gen #(
    parameter int BLK_W    = 26,
    parameter int OFF_W    = 6,
    parameter int SLOTS    = 16,
    parameter int STRUCT_W = 20,
    parameter int CNT_W    = 2,
    parameter int DEGREE   = 4,
    parameter int PRIO_W   = 2
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic                              trig_valid,
    output logic                              trig_ready,
    input  logic [BLK_W-1:0]                  trig_blk,
    input  logic                              trig_secure,
    output logic                              ps_rd_en,
    output logic [BLK_W-$clog2(SLOTS)-1:0]    ps_rd_tag,
    output logic [$clog2(SLOTS)-1:0]          ps_rd_slot,
    output logic                              ps_rd_secure,
    input  logic                              ps_rd_hit,
    input  logic [CNT_W-1:0]                  ps_rd_cnt,
    input  logic [STRUCT_W-1:0]               ps_rd_saddr,
    output logic                              sp_rd_en,
    output logic [STRUCT_W-$clog2(SLOTS)-1:0] sp_rd_tag,
    output logic [$clog2(SLOTS)-1:0]          sp_rd_slot,
    output logic                              sp_rd_secure,
    input  logic                              sp_rd_hit,
    input  logic [CNT_W-1:0]                  sp_rd_cnt,
    input  logic [BLK_W-1:0]                  sp_rd_blk,
    output logic                              pf_valid,
    input  logic                              pf_ready,
    output logic [BLK_W+OFF_W-1:0]            pf_addr,
    output logic                              pf_secure,
    output logic [PRIO_W-1:0]                 pf_prio,
    output logic                              pf_err
);
    import sgen_pkg::*;

    localparam int SLOT_W = $clog2(SLOTS);
    localparam int STEP_W = $clog2(DEGREE+1);
    localparam int ADDR_W = BLK_W + OFF_W;

    typedef struct packed {
        sgen_state_e         st;
        logic [BLK_W-1:0]    blk;
        logic                sec;
        logic [STRUCT_W-1:0] sa;
        logic [STEP_W-1:0]   step;
        logic                err;
    } ctl_t;

    ctl_t ctl_d, ctl_q;

    logic [SLOT_W-1:0] walk_slot;
    logic              walk_last;
    logic              out_free;
    logic              out_load;
    logic              out_load_valid;
    logic [ADDR_W-1:0] out_load_data;

    sgen_slot_walker #(.SLOTS(SLOTS), .DEGREE(DEGREE)) u_walker (
        .base_slot (ctl_q.sa[SLOT_W-1:0]),
        .step      (ctl_q.step),
        .slot      (walk_slot),
        .last      (walk_last)
    );

    assign out_free      = !pf_valid || pf_ready;
    assign out_load_data = {sp_rd_blk, {OFF_W{1'b0}}};

    always_comb begin
        ctl_d          = ctl_q;
        ctl_d.err      = 1'b0;
        out_load       = 1'b0;
        out_load_valid = 1'b0;
        ps_rd_en       = 1'b0;
        sp_rd_en       = 1'b0;
        ps_rd_tag      = ctl_q.blk[BLK_W-1:SLOT_W];
        ps_rd_slot     = ctl_q.blk[SLOT_W-1:0];
        sp_rd_tag      = ctl_q.sa[STRUCT_W-1:SLOT_W];
        sp_rd_slot     = (ctl_q.st == ST_WALK) ? walk_slot : ctl_q.sa[SLOT_W-1:0];
        unique case (ctl_q.st)
            ST_IDLE: begin
                if (trig_valid) begin
                    ctl_d.blk = trig_blk;
                    ctl_d.sec = trig_secure;
                    ctl_d.st  = ST_PSLK;
                end
            end
            ST_PSLK: begin
                ps_rd_en = 1'b1;
                if (ps_rd_hit && (ps_rd_cnt != '0)) begin
                    ctl_d.sa = ps_rd_saddr;
                    ctl_d.st = ST_SPCHK;
                end else begin
                    ctl_d.st = ST_IDLE;
                end
            end
            ST_SPCHK: begin
                sp_rd_en = 1'b1;
                if (!sp_rd_hit) begin
                    ctl_d.err = 1'b1;
                    ctl_d.st  = ST_IDLE;
                end else if (ctl_q.sa[SLOT_W-1:0] == SLOT_W'(SLOTS-1)) begin
                    ctl_d.st = ST_IDLE;
                end else begin
                    ctl_d.step = STEP_W'(1);
                    ctl_d.st   = ST_WALK;
                end
            end
            ST_WALK: begin
                sp_rd_en = 1'b1;
                if (out_free) begin
                    out_load       = 1'b1;
                    out_load_valid = sp_rd_hit && (sp_rd_cnt != '0);
                    if (walk_last) ctl_d.st   = ST_DRAIN;
                    else           ctl_d.step = ctl_q.step + STEP_W'(1);
                end
            end
            ST_DRAIN: begin
                if (out_free) ctl_d.st = ST_IDLE;
            end
            default: ctl_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctl_q    <= '0;
            ctl_q.st <= ST_IDLE;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    sgen_pf_out #(.W(ADDR_W)) u_out (
        .clk        (clk),
        .rst_n      (rst_n),
        .load       (out_load),
        .load_valid (out_load_valid),
        .load_data  (out_load_data),
        .pop        (pf_ready),
        .valid      (pf_valid),
        .data       (pf_addr)
    );

    assign trig_ready   = (ctl_q.st == ST_IDLE);
    assign ps_rd_secure = ctl_q.sec;
    assign sp_rd_secure = ctl_q.sec;
    assign pf_secure    = ctl_q.sec;
    assign pf_prio      = '0;
    assign pf_err       = ctl_q.err;
endmodule

// File: rtl/sgen_prefetch_chk.sv
module sgen_prefetch_chk #(
    parameter int DEGREE = 4,
    parameter int ADDR_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              trig_valid,
    input logic              trig_ready,
    input logic              pf_valid,
    input logic              pf_ready,
    input logic [ADDR_W-1:0] pf_addr,
    input logic              pf_err
);
    localparam int CW = $clog2(DEGREE+2) + 1;

    logic [CW-1:0] burst_cnt;

    always_ff @(posedge clk) begin
        if (!rst_n)                        burst_cnt <= '0;
        else if (trig_valid && trig_ready) burst_cnt <= '0;
        else if (pf_valid && pf_ready)     burst_cnt <= burst_cnt + CW'(1);
    end

    p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (pf_valid && !pf_ready) |=> (pf_valid && $stable(pf_addr)));

    p_busy_r9: assert property (@(posedge clk) disable iff (!rst_n)
        pf_valid |-> !trig_ready);

    p_err_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n)
        pf_err |-> (!pf_valid && trig_ready));

    p_degree_cap_r4: assert property (@(posedge clk) disable iff (!rst_n)
        burst_cnt <= CW'(DEGREE));
endmodule

bind sgen_prefetch_gen sgen_prefetch_chk #(
    .DEGREE (DEGREE),
    .ADDR_W (BLK_W + OFF_W)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .trig_valid (trig_valid),
    .trig_ready (trig_ready),
    .pf_valid   (pf_valid),
    .pf_ready   (pf_ready),
    .pf_addr    (pf_addr),
    .pf_err     (pf_err)
);

// File: tb/tb_sgen_prefetch_gen.sv
`timescale 1ns/1ps
module tb_sgen_prefetch_gen;
    localparam int BLK_W = 26, OFF_W = 6, STRUCT_W = 20, CNT_W = 2, DEGREE = 4, PRIO_W = 2;
    localparam int PST_W = BLK_W - 4, SPT_W = STRUCT_W - 4, ADDR_W = BLK_W + OFF_W;
    localparam int NL = 4;

    logic clk = 0, rst_n = 0;
    logic trig_valid = 0, trig_secure = 0, pf_ready = 0;
    logic [BLK_W-1:0] trig_blk = '0;
    logic trig_ready, ps_rd_en, ps_rd_secure, sp_rd_en, sp_rd_secure;
    logic [PST_W-1:0] ps_rd_tag;
    logic [SPT_W-1:0] sp_rd_tag;
    logic [3:0] ps_rd_slot, sp_rd_slot;
    logic ps_rd_hit, sp_rd_hit;
    logic [CNT_W-1:0] ps_rd_cnt, sp_rd_cnt;
    logic [STRUCT_W-1:0] ps_rd_saddr;
    logic [BLK_W-1:0] sp_rd_blk;
    logic pf_valid, pf_secure, pf_err;
    logic [ADDR_W-1:0] pf_addr;
    logic [PRIO_W-1:0] pf_prio;

    always #5 clk = ~clk;

    sgen_prefetch_gen dut (
        .clk(clk), .rst_n(rst_n), .trig_valid(trig_valid), .trig_ready(trig_ready),
        .trig_blk(trig_blk), .trig_secure(trig_secure),
        .ps_rd_en(ps_rd_en), .ps_rd_tag(ps_rd_tag), .ps_rd_slot(ps_rd_slot),
        .ps_rd_secure(ps_rd_secure), .ps_rd_hit(ps_rd_hit), .ps_rd_cnt(ps_rd_cnt),
        .ps_rd_saddr(ps_rd_saddr),
        .sp_rd_en(sp_rd_en), .sp_rd_tag(sp_rd_tag), .sp_rd_slot(sp_rd_slot),
        .sp_rd_secure(sp_rd_secure), .sp_rd_hit(sp_rd_hit), .sp_rd_cnt(sp_rd_cnt),
        .sp_rd_blk(sp_rd_blk),
        .pf_valid(pf_valid), .pf_ready(pf_ready), .pf_addr(pf_addr),
        .pf_secure(pf_secure), .pf_prio(pf_prio), .pf_err(pf_err)
    );

    // Map models
    logic [PST_W-1:0]    ps_tag_t [NL];
    logic                ps_sec_t [NL];
    logic                ps_v_t   [NL];
    logic [CNT_W-1:0]    ps_cnt_t [NL][16];
    logic [STRUCT_W-1:0] ps_sa_t  [NL][16];
    logic [SPT_W-1:0]    sp_tag_t [NL];
    logic                sp_sec_t [NL];
    logic                sp_v_t   [NL];
    logic [CNT_W-1:0]    sp_cnt_t [NL][16];
    logic [BLK_W-1:0]    sp_pa_t  [NL][16];

    always_comb begin
        ps_rd_hit = 0; ps_rd_cnt = '0; ps_rd_saddr = '0;
        for (int i = 0; i < NL; i++)
            if (ps_v_t[i] && ps_tag_t[i] == ps_rd_tag && ps_sec_t[i] == ps_rd_secure) begin
                ps_rd_hit = 1; ps_rd_cnt = ps_cnt_t[i][ps_rd_slot]; ps_rd_saddr = ps_sa_t[i][ps_rd_slot];
            end
        sp_rd_hit = 0; sp_rd_cnt = '0; sp_rd_blk = '0;
        for (int i = 0; i < NL; i++)
            if (sp_v_t[i] && sp_tag_t[i] == sp_rd_tag && sp_sec_t[i] == sp_rd_secure) begin
                sp_rd_hit = 1; sp_rd_cnt = sp_cnt_t[i][sp_rd_slot]; sp_rd_blk = sp_pa_t[i][sp_rd_slot];
            end
    end

    int total = 0, bad = 0;
    bit done = 0;

    task automatic chk(bit ok, string req, logic [63:0] act, logic [63:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic clear_maps();
        for (int i = 0; i < NL; i++) begin
            ps_v_t[i] = 0; sp_v_t[i] = 0; ps_tag_t[i] = '0; sp_tag_t[i] = '0;
            ps_sec_t[i] = 0; sp_sec_t[i] = 0;
            for (int k = 0; k < 16; k++) begin
                ps_cnt_t[i][k] = '0; ps_sa_t[i][k] = '0; sp_cnt_t[i][k] = '0; sp_pa_t[i][k] = '0;
            end
        end
    endtask

    task automatic rand_maps();
        for (int i = 0; i < NL; i++) begin
            ps_v_t[i] = ($urandom % 4) != 0; ps_tag_t[i] = PST_W'(i); ps_sec_t[i] = $urandom % 2;
            sp_v_t[i] = ($urandom % 4) != 0; sp_tag_t[i] = SPT_W'(i); sp_sec_t[i] = $urandom % 2;
            for (int k = 0; k < 16; k++) begin
                ps_cnt_t[i][k] = CNT_W'($urandom % 4);
                ps_sa_t[i][k]  = STRUCT_W'($urandom % 64);
                sp_cnt_t[i][k] = (($urandom % 3) == 0) ? '0 : CNT_W'(1 + $urandom % 3);
                sp_pa_t[i][k]  = BLK_W'($urandom);
            end
        end
    endtask

    // Reference behaviour from the requirements
    int exp_n; bit exp_err; logic [ADDR_W-1:0] exp_a [8];
    task automatic model(logic [BLK_W-1:0] b, logic s);
        int pl, sl; logic [STRUCT_W-1:0] sa; int base;
        exp_n = 0; exp_err = 0; pl = -1; sl = -1;
        for (int i = 0; i < NL; i++)
            if (ps_v_t[i] && ps_tag_t[i] == b[BLK_W-1:4] && ps_sec_t[i] == s) pl = i;
        if (pl < 0) return;
        if (ps_cnt_t[pl][b[3:0]] == 0) return;
        sa = ps_sa_t[pl][b[3:0]];
        for (int i = 0; i < NL; i++)
            if (sp_v_t[i] && sp_tag_t[i] == sa[STRUCT_W-1:4] && sp_sec_t[i] == s) sl = i;
        if (sl < 0) begin exp_err = 1; return; end
        base = int'(sa[3:0]);
        for (int d = 1; d <= DEGREE && base + d < 16; d++)
            if (sp_cnt_t[sl][base+d] != 0) begin
                exp_a[exp_n] = {sp_pa_t[sl][base+d], {OFF_W{1'b0}}};
                exp_n++;
            end
    endtask

    task automatic run_one(logic [BLK_W-1:0] b, logic s, string req);
        int got_n = 0, got_err = 0, guard = 0;
        logic [ADDR_W-1:0] got_a [8];
        bit hold = 0; logic [ADDR_W-1:0] hold_a = '0;
        model(b, s);
        @(negedge clk);
        trig_valid = 1; trig_blk = b; trig_secure = s;
        @(posedge clk); #1 trig_valid = 0;
        @(negedge clk);
        chk(trig_ready == 0, "R9 busy after accept", trig_ready, 0);
        forever begin
            if (pf_err) got_err++;
            if (hold) chk(pf_valid && pf_addr == hold_a, "R8 hold", pf_addr, hold_a);
            if (trig_ready) break;
            pf_ready = ($urandom % 3) != 0;
            hold = 0;
            if (pf_valid) begin
                if (pf_ready) begin
                    if (got_n < 8) got_a[got_n] = pf_addr;
                    got_n++;
                    chk(pf_secure == s, "R7 secure", pf_secure, s);
                    chk(pf_prio == 0, "R7 prio", pf_prio, 0);
                end else begin
                    hold = 1; hold_a = pf_addr;
                end
            end
            guard++;
            if (guard > 200) begin chk(0, "R9 walk hang", guard, 0); break; end
            @(negedge clk);
        end
        pf_ready = 0;
        chk(got_err == int'(exp_err), "R3 error pulse", got_err, exp_err);
        chk(got_n == exp_n, req, got_n, exp_n);
        for (int k = 0; k < exp_n && k < got_n; k++)
            chk(got_a[k] == exp_a[k], "R7 R4 address order", got_a[k], exp_a[k]);
    endtask

    initial begin
        int seed;
        seed = $urandom(32'd1234);
        clear_maps();
        repeat (3) @(negedge clk);
        chk(trig_ready == 1 && pf_valid == 0 && pf_err == 0, "R1 reset outputs",
            {trig_ready, pf_valid, pf_err}, 3'b100);
        rst_n = 1;
        @(negedge clk);
        chk(trig_ready == 1 && pf_valid == 0 && pf_err == 0, "R1 after reset",
            {trig_ready, pf_valid, pf_err}, 3'b100);

        run_one(26'h123, 0, "R2 empty map count");
        ps_v_t[0] = 1; ps_tag_t[0] = 22'h5; ps_sec_t[0] = 0;
        run_one(26'h53, 0, "R2 zero counter count");
        ps_cnt_t[0][3] = 2; ps_sa_t[0][3] = 20'h70;
        run_one(26'h53, 0, "R3 missing line count");
        sp_v_t[0] = 1; sp_tag_t[0] = 16'h7; sp_sec_t[0] = 0;
        for (int k = 0; k < 16; k++) begin sp_cnt_t[0][k] = 1; sp_pa_t[0][k] = BLK_W'(26'h100 + k); end
        run_one(26'h53, 0, "R4 full degree count");
        run_one(26'h53, 1, "R2 secure mismatch count");
        ps_sa_t[0][3] = 20'h7E;
        run_one(26'h53, 0, "R5 slot 14 count");
        ps_sa_t[0][3] = 20'h7F;
        run_one(26'h53, 0, "R5 slot 15 count");
        ps_sa_t[0][3] = 20'h7C;
        run_one(26'h53, 0, "R5 slot 12 count");
        ps_sa_t[0][3] = 20'h70; sp_cnt_t[0][2] = 0; sp_cnt_t[0][4] = 0;
        run_one(26'h53, 0, "R6 holes count");

        for (int n = 0; n < 300; n++) begin
            if (n % 20 == 0) rand_maps();
            run_one({($urandom % 5) == 4 ? 22'h9 : 22'($urandom % 4), 4'($urandom)},
                    ($urandom % 2), "R4 R5 R6 random count");
        end
        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule